// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Entry and Exit Sequencer

This block sits on the host side of a pseudo-SRAM and moves the memory into and out of its low-power state. A single request interface carries a command bit (enter or leave low power) and, for entry, a five-bit configuration word. The memory accepts that word as a register write that is encoded on its five lowest address lines. The write happens during a write-strobe pulse, which must begin shortly after the sleep line is pulled low.

On an entry request the sequencer asks the pin arbiter for the memory pins and waits for the grant. It then deselects the chip, pulls the sleep line low, and presents the configuration on the address lines. It pulses the write strobe together with chip select and both byte strobes, lets the write recover, and then rests in the low-power state. The pins stay owned for the whole time the memory sleeps. On a wake request it keeps the sleep line low until the minimum deep-sleep dwell has passed. It then raises the sleep line, waits the recovery time that matches the chosen mode, releases the pins and reports that the memory is usable. Deep sleep wipes the memory's configuration register, so every entry rewrites it.

All times are counted in clock cycles and set through parameters.

Top module: `psram_lp_seq`

## Requirements
- R1: Before the sleep line falls, chip select and both byte strobes are held high (deselected) for DESEL_CYC cycles with the sleep line still high.
- R2: The write strobe falls SETUP_CYC cycles after the sleep line falls, which is fewer than DEADLINE_CYC cycles. Chip select and both byte strobes go low together with it.
- R3: mem_addr[i] carries configuration bit i from the fall of the sleep line to the end of write recovery and does not change during that time. The write strobe stays low for PULSE_CYC cycles and then high for RECOV_CYC cycles. mem_addr is zero at all other times.
- R4: Configuration bit 4 = 0 selects deep sleep. In that mode the sleep line stays low for more than MIN_SLEEP_CYC cycles. A wake request that arrives earlier is accepted and held until that time has passed.
- R5: After the sleep line rises, mem_usable returns high after WAKE_CYC cycles when deep sleep was selected, or after LIGHT_WAKE_CYC cycles when configuration bit 4 = 1. It does not return high any earlier.
- R6: An accepted entry request raises bus_req on the next cycle. No memory pin leaves its idle value until bus_gnt is seen. bus_req stays high through the sleep and falls when the memory is usable again.
- R7: done is a one-cycle pulse. It fires on the cycle the low-power state is reached and again on the cycle the memory becomes usable after a wake.
- R8: req_ready is high only while awake-idle or asleep. A wake command while awake-idle has no effect, and an entry command while asleep has no effect.
- R9: After reset the sleep line, chip select, write strobe and byte strobes are high, mem_addr is zero, bus_req and done are low, and mem_usable and req_ready are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command valid |
| req_sleep | input | 1 | 1 = enter low power, 0 = wake |
| req_cfg | input | 5 | Configuration word written on entry |
| req_ready | output | 1 | Command can be accepted |
| bus_req | output | 1 | Request for ownership of the memory pins |
| bus_gnt | input | 1 | Pin ownership granted |
| mem_sleep_n | output | 1 | Memory sleep line, low = low-power |
| mem_sel_n | output | 1 | Memory chip select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_hi_n | output | 1 | Upper byte strobe, active low |
| mem_lo_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 5 | Lowest five memory address lines |
| mem_usable | output | 1 | Memory awake and free for normal access |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench times an early wake in deep sleep. A design that obeys the wake at once would raise the sleep line before the minimum dwell, and that shows up as an early sleep-rise event. It also holds the grant back for several cycles: a design that deselects without waiting would move pins before ownership. Commands given in the wrong state are checked at the pins, because a design that acted on them would start a write pulse or take the bus. The two recovery lengths are told apart per mode, so a design that used one length for both would report usable at the wrong cycle.

// File: rtl/psram_lp_pkg.sv
package psram_lp_pkg;

  localparam int CFG_W    = 5;
  localparam int KEEP_BIT = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACQ,
    ST_DESEL,
    ST_SETUP,
    ST_PULSE,
    ST_RECOV,
    ST_ASLEEP,
    ST_DWELL,
    ST_WAKE
  } lp_state_e;

  // bit 4 clear means the memory drops into deep sleep
  function automatic logic deep_sleep_on(input logic [CFG_W-1:0] cfg);
    return !cfg[KEEP_BIT];
  endfunction

  function automatic int unsigned wake_len(input logic [CFG_W-1:0] cfg,
                                           input int unsigned deep_len,
                                           input int unsigned light_len);
    return deep_sleep_on(cfg) ? deep_len : light_len;
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic sleep_phase(input lp_state_e st);
    return st inside {ST_SETUP, ST_PULSE, ST_RECOV, ST_ASLEEP, ST_DWELL};
  endfunction

  function automatic logic cfg_phase(input lp_state_e st);
    return st inside {ST_SETUP, ST_PULSE, ST_RECOV};
  endfunction

endpackage

// File: rtl/lp_timer.sv
module lp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lp_dwell.sv
module lp_dwell #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ok
);
  localparam int W = $clog2(LIMIT + 1) + 1;
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign ok = (cnt == LIM);
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import psram_lp_pkg::*;
#(
  parameter int DESEL_CYC      = 2,
  parameter int SETUP_CYC      = 1,
  parameter int PULSE_CYC      = 6,
  parameter int RECOV_CYC      = 1,
  parameter int WAKE_CYC       = 20000,
  parameter int LIGHT_WAKE_CYC = 2,
  parameter int TW             = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_sleep,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic             bus_gnt,
  input  logic             t_zero,
  input  logic             dwell_ok,
  output lp_state_e        state,
  output logic             t_load,
  output logic [TW-1:0]    t_val,
  output logic [CFG_W-1:0] cfg_q,
  output logic             enter_done,
  output logic             wake_done,
  output logic             done
);
  lp_state_e nxt;
  logic      take_cfg;

  always_comb begin
    nxt      = state;
    t_load   = 1'b0;
    t_val    = '0;
    take_cfg = 1'b0;
    unique case (state)
      ST_IDLE:
        if (req_valid && req_sleep) begin
          nxt      = ST_ACQ;
          take_cfg = 1'b1;
        end
      ST_ACQ:
        if (bus_gnt) begin
          nxt    = ST_DESEL;
          t_load = 1'b1;
          t_val  = TW'(DESEL_CYC - 1);
        end
      ST_DESEL:
        if (t_zero) begin
          nxt    = ST_SETUP;
          t_load = 1'b1;
          t_val  = TW'(SETUP_CYC - 1);
        end
      ST_SETUP:
        if (t_zero) begin
          nxt    = ST_PULSE;
          t_load = 1'b1;
          t_val  = TW'(PULSE_CYC - 1);
        end
      ST_PULSE:
        if (t_zero) begin
          nxt    = ST_RECOV;
          t_load = 1'b1;
          t_val  = TW'(RECOV_CYC - 1);
        end
      ST_RECOV:
        if (t_zero) nxt = ST_ASLEEP;
      ST_ASLEEP:
        if (req_valid && !req_sleep) nxt = ST_DWELL;
      ST_DWELL:
        if (dwell_ok || !deep_sleep_on(cfg_q)) begin
          nxt    = ST_WAKE;
          t_load = 1'b1;
          t_val  = TW'(wake_len(cfg_q, WAKE_CYC, LIGHT_WAKE_CYC) - 1);
        end
      ST_WAKE:
        if (t_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign enter_done = (state == ST_RECOV) && (nxt == ST_ASLEEP);
  assign wake_done  = (state == ST_WAKE)  && (nxt == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (take_cfg) cfg_q <= req_cfg;
      done  <= enter_done || wake_done;
    end
  end
endmodule

// File: rtl/psram_lp_seq.sv
module psram_lp_seq
  import psram_lp_pkg::*;
#(
  parameter int DESEL_CYC      = 2,
  parameter int SETUP_CYC      = 1,
  parameter int PULSE_CYC      = 6,
  parameter int RECOV_CYC      = 1,
  parameter int DEADLINE_CYC   = 100,
  parameter int MIN_SLEEP_CYC  = 1000,
  parameter int WAKE_CYC       = 20000,
  parameter int LIGHT_WAKE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_sleep,
  input  logic [4:0] req_cfg,
  output logic       req_ready,
  output logic       bus_req,
  input  logic       bus_gnt,
  output logic       mem_sleep_n,
  output logic       mem_sel_n,
  output logic       mem_wr_n,
  output logic       mem_hi_n,
  output logic       mem_lo_n,
  output logic [4:0] mem_addr,
  output logic       mem_usable,
  output logic       done
);
  localparam int PHASE_MAX = max_of(max_of(DESEL_CYC, SETUP_CYC),
                                    max_of(PULSE_CYC, RECOV_CYC));
  localparam int LONGEST   = max_of(PHASE_MAX,
                                    max_of(WAKE_CYC, LIGHT_WAKE_CYC));
  localparam int TW        = $clog2(LONGEST + 1);

  generate
    if (SETUP_CYC >= DEADLINE_CYC) begin : g_bad_setup
      $error("write setup does not fit inside the configuration window");
    end
  endgenerate

  lp_state_e        state;
  logic             t_load;
  logic [TW-1:0]    t_val;
  logic             t_zero;
  logic             dwell_ok;
  logic [CFG_W-1:0] cfg_q;
  logic             sleep_low;
  logic             strobe_on;
  logic             enter_done;
  logic             wake_done;

  lp_fsm #(
    .DESEL_CYC     (DESEL_CYC),
    .SETUP_CYC     (SETUP_CYC),
    .PULSE_CYC     (PULSE_CYC),
    .RECOV_CYC     (RECOV_CYC),
    .WAKE_CYC      (WAKE_CYC),
    .LIGHT_WAKE_CYC(LIGHT_WAKE_CYC),
    .TW            (TW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sleep (req_sleep),
    .req_cfg   (req_cfg),
    .bus_gnt   (bus_gnt),
    .t_zero    (t_zero),
    .dwell_ok  (dwell_ok),
    .state     (state),
    .t_load    (t_load),
    .t_val     (t_val),
    .cfg_q     (cfg_q),
    .enter_done(enter_done),
    .wake_done (wake_done),
    .done      (done)
  );

  lp_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .zero    (t_zero)
  );

  lp_dwell #(.LIMIT(MIN_SLEEP_CYC)) u_dwell (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (sleep_low),
    .ok   (dwell_ok)
  );

  assign sleep_low   = sleep_phase(state);
  assign strobe_on   = (state == ST_PULSE);

  assign mem_sleep_n = !sleep_low;
  assign mem_sel_n   = !strobe_on;
  assign mem_wr_n    = !strobe_on;
  assign mem_hi_n    = !strobe_on;
  assign mem_lo_n    = !strobe_on;
  assign mem_addr    = cfg_phase(state) ? cfg_q : '0;

  assign bus_req     = (state != ST_IDLE);
  assign mem_usable  = (state == ST_IDLE);
  assign req_ready   = (state == ST_IDLE) || (state == ST_ASLEEP);
endmodule

// File: rtl/psram_lp_seq_chk.sv
module psram_lp_seq_chk #(
  parameter int DEADLINE_CYC   = 100,
  parameter int MIN_SLEEP_CYC  = 1000,
  parameter int WAKE_CYC       = 20000,
  parameter int LIGHT_WAKE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       mem_sleep_n,
  input logic       mem_sel_n,
  input logic       mem_wr_n,
  input logic       mem_hi_n,
  input logic       mem_lo_n,
  input logic [4:0] mem_addr,
  input logic       mem_usable,
  input logic       done
);
  localparam int LW = $clog2(MIN_SLEEP_CYC + DEADLINE_CYC + 2) + 1;
  localparam int HW = $clog2(WAKE_CYC + LIGHT_WAKE_CYC + 2) + 1;

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic          deep_chk;
  logic          gnt_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      deep_chk <= 1'b0;
      gnt_seen <= 1'b0;
    end else begin
      if (mem_sleep_n)        low_cnt <= '0;
      else if (~&low_cnt)     low_cnt <= low_cnt + 1'b1;
      if (!mem_sleep_n)       high_cnt <= '0;
      else if (~&high_cnt)    high_cnt <= high_cnt + 1'b1;
      if (!mem_wr_n)          deep_chk <= !mem_addr[4];
      if (!bus_req)           gnt_seen <= 1'b0;
      else if (bus_gnt)       gnt_seen <= 1'b1;
    end
  end

  p_desel_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_sleep_n) |-> ($past(mem_sel_n) && $past(mem_hi_n) &&
                            $past(mem_lo_n) && mem_sel_n));

  p_cfg_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> (!mem_sleep_n && !mem_sel_n && !mem_hi_n && !mem_lo_n &&
                         (low_cnt < LW'(DEADLINE_CYC))));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n || $rose(mem_wr_n)) |-> $stable(mem_addr));

  p_min_dwell_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_sleep_n) && deep_chk) |-> (low_cnt >= LW'(MIN_SLEEP_CYC)));

  p_wake_recov_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_usable) |->
      (high_cnt >= (deep_chk ? HW'(WAKE_CYC) : HW'(LIGHT_WAKE_CYC))));

  p_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sleep_n || !mem_wr_n || !mem_sel_n) |-> gnt_seen);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_usable |-> (mem_sleep_n && mem_wr_n && mem_sel_n && !bus_req &&
                    (mem_addr == 5'd0)));
endmodule

bind psram_lp_seq psram_lp_seq_chk #(
  .DEADLINE_CYC  (DEADLINE_CYC),
  .MIN_SLEEP_CYC (MIN_SLEEP_CYC),
  .WAKE_CYC      (WAKE_CYC),
  .LIGHT_WAKE_CYC(LIGHT_WAKE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .mem_sleep_n(mem_sleep_n),
  .mem_sel_n  (mem_sel_n),
  .mem_wr_n   (mem_wr_n),
  .mem_hi_n   (mem_hi_n),
  .mem_lo_n   (mem_lo_n),
  .mem_addr   (mem_addr),
  .mem_usable (mem_usable),
  .done       (done)
);

// File: tb/psram_lp_seq_tb.sv
module psram_lp_seq_tb;
  localparam int DESEL = 2;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int RECOV = 2;
  localparam int DLINE = 10;
  localparam int MINS  = 20;
  localparam int WAKE  = 40;
  localparam int LIGHT = 3;

  localparam int EV_REQ = 0, EV_SF = 1, EV_WF = 2, EV_WR = 3, EV_SR = 4, EV_DONE = 5;

  typedef struct {
    int kind;
    int cyc;
    int addr;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_sleep = 1'b0;
  logic [4:0] req_cfg = '0;
  logic       bus_gnt = 1'b0;
  logic       req_ready, bus_req, mem_sleep_n, mem_sel_n, mem_wr_n;
  logic       mem_hi_n, mem_lo_n, mem_usable, done;
  logic [4:0] mem_addr;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  finished = 1'b0;
  ev_t exp_q[$];
  logic p_req = 1'b0, p_sleep = 1'b1, p_wr = 1'b1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_lp_seq #(
    .DESEL_CYC(DESEL), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV),
    .DEADLINE_CYC(DLINE), .MIN_SLEEP_CYC(MINS), .WAKE_CYC(WAKE),
    .LIGHT_WAKE_CYC(LIGHT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sleep(req_sleep),
    .req_cfg(req_cfg), .req_ready(req_ready), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_sleep_n(mem_sleep_n), .mem_sel_n(mem_sel_n),
    .mem_wr_n(mem_wr_n), .mem_hi_n(mem_hi_n), .mem_lo_n(mem_lo_n),
    .mem_addr(mem_addr), .mem_usable(mem_usable), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  function automatic string ev_req(input int k);
    case (k)
      EV_REQ:  return "R6";
      EV_SF:   return "R1";
      EV_WF:   return "R2";
      EV_WR:   return "R3";
      EV_SR:   return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic push(input int k, input int c, input int a);
    ev_t e;
    e.kind = k; e.cyc = c; e.addr = a;
    exp_q.push_back(e);
  endtask

  task automatic match(input int k, input int a);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, ev_req(k), k, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, ev_req(e.kind), k, e.kind);
      check(e.cyc == cyc, ev_req(e.kind), cyc, e.cyc);
      if (k == EV_WF) check(e.addr == a, "R3", a, e.addr);
    end
  endtask

  // monitor: turns pin edges into events and compares them with the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_req && !p_req)      match(EV_REQ, 0);
      if (!mem_sleep_n && p_sleep) match(EV_SF, int'(mem_addr));
      if (!mem_wr_n && p_wr)       match(EV_WF, int'(mem_addr));
      if (mem_wr_n && !p_wr)       match(EV_WR, 0);
      if (mem_sleep_n && !p_sleep) match(EV_SR, 0);
      if (done)                    match(EV_DONE, 0);
    end
    p_req = bus_req; p_sleep = mem_sleep_n; p_wr = mem_wr_n;
  end

  task automatic sleep_seq(input logic [4:0] cfg, input int g, output int s);
    int a, last;
    @(negedge clk);
    a = cyc + 1;
    s = a + g + 1 + DESEL;
    last = s + SETUP + PULSE + RECOV;
    push(EV_REQ, a, 0);
    push(EV_SF, s, 0);
    push(EV_WF, s + SETUP, int'(cfg));
    push(EV_WR, s + SETUP + PULSE, 0);
    push(EV_DONE, last, 0);
    req_valid = 1'b1; req_sleep = 1'b1; req_cfg = cfg;
    do begin
      @(negedge clk);
      if (cyc == a) begin
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", req_ready, 0);
        if (g > 0) check(mem_sleep_n && mem_sel_n && mem_wr_n, "R6", mem_sel_n, 1);
      end
      if (cyc == a + g) bus_gnt = 1'b1;
      if (cyc == s - 1)
        check(mem_sel_n && mem_hi_n && mem_lo_n && mem_sleep_n, "R1",
              {mem_sel_n, mem_hi_n, mem_lo_n, mem_sleep_n}, 15);
      if (cyc == s + SETUP) begin
        check(!mem_sel_n && !mem_hi_n && !mem_lo_n, "R2",
              {mem_sel_n, mem_hi_n, mem_lo_n}, 0);
        check(mem_addr == cfg, "R3", mem_addr, cfg);
      end
      if (cyc == s + SETUP + PULSE)
        check(mem_wr_n && mem_addr == cfg, "R3", mem_addr, cfg);
    end while (cyc < last);
    check(req_ready == 1'b1, "R8", req_ready, 1);
    check(mem_sleep_n == 1'b0 && mem_addr == 5'd0, "R3", mem_addr, 0);
  endtask

  task automatic wake_seq(input bit deep, input int s);
    int w, e, l;
    @(negedge clk);
    w = cyc + 1;
    e = w + 1;
    if (deep && (s + MINS + 1 > e)) e = s + MINS + 1;
    l = deep ? WAKE : LIGHT;
    push(EV_SR, e, 0);
    push(EV_DONE, e + l, 0);
    req_valid = 1'b1; req_sleep = 1'b0;
    do begin
      @(negedge clk);
      if (cyc == w) req_valid = 1'b0;
      if (cyc == w + 1 && e > w + 1)
        check(mem_sleep_n == 1'b0, "R4", mem_sleep_n, 0);
      if (cyc == e + l - 1) check(mem_usable == 1'b0, "R5", mem_usable, 0);
    end while (cyc < e + l);
    check(mem_usable == 1'b1, "R5", mem_usable, 1);
    check(bus_req == 1'b0, "R6", bus_req, 0);
    @(negedge clk);
    check(done == 1'b0, "R7", done, 0);
    bus_gnt = 1'b0;
  endtask

  initial begin
    int s;
    repeat (2) @(negedge clk);
    // R9 reset values
    check(mem_sleep_n && mem_sel_n && mem_wr_n && mem_hi_n && mem_lo_n, "R9", mem_sel_n, 1);
    check(mem_addr == 5'd0 && !bus_req && !done, "R9", bus_req, 0);
    check(mem_usable && req_ready, "R9", mem_usable, 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // deep sleep, immediate grant, early wake deferred (R4, R5)
    sleep_seq(5'b00110, 0, s);
    wake_seq(1'b1, s);

    // keep-data mode, late grant, short recovery
    sleep_seq(5'b11011, 3, s);
    repeat (5) @(negedge clk);
    wake_seq(1'b0, s);

    // R8: wake command while awake-idle is ignored
    @(negedge clk);
    req_valid = 1'b1; req_sleep = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(!bus_req && mem_sleep_n && mem_usable, "R8", bus_req, 0);

    // deep sleep, wake only after dwell has passed; entry command while asleep ignored
    sleep_seq(5'b01001, 1, s);
    @(negedge clk);
    req_valid = 1'b1; req_sleep = 1'b1; req_cfg = 5'b11111;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(!mem_sleep_n && mem_wr_n && mem_addr == 5'd0, "R8", mem_addr, 0);
    repeat (MINS) @(negedge clk);
    wake_seq(1'b1, s);

    // keep-data mode, wake at once
    sleep_seq(5'b10000, 0, s);
    wake_seq(1'b0, s);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule